// File: doc/BRIEF.md
# Masked Multi-Address Packet Filter

This block sits behind the sync-word detector of a packet receiver and decides whether an incoming packet is addressed to this node. It counts the payload bytes from the packet-start strobe and copies a window of N address bytes, starting at a programmable payload position, into a small buffer. Once the window is complete it walks a list of stored addresses held in a 21-byte configuration memory. It compares the buffer with each entry in turn, one match/mask byte pair per clock, and stops at the first entry that hits or at the end of the list.

The host writes the configuration memory through an address/data/write-enable port. Byte 0 holds the payload position of the first address byte; position 0 is the first byte after the sync word. Byte 1 holds the first length N. Bytes from 2 onward hold the entries. Each entry is N pairs of a match byte followed by its mask byte, and the length byte of the next entry follows the last pair. A mask bit of 1 compares the received bit and a mask bit of 0 ignores it. This lets one entry describe a broadcast or family address, for example 0xAA in the first byte with the remaining bytes masked off.

The controller has five states:
- IDLE: entered after reset.
- COLLECT: counting and capturing bytes.
- LEN: checking an entry's length byte.
- CMP: comparing one byte pair per clock.
- DONE: holding the verdict.

Its transitions are:
- start: any state to COLLECT, or to DONE when checking is disabled or N is too large.
- window-complete: COLLECT to LEN.
- early-end: COLLECT to DONE.
- entry-accept: LEN to CMP.
- list-end: LEN to DONE.
- entry-miss: CMP to LEN.
- entry-hit: CMP to DONE.

Top module: `addr_filter`

## Requirements
- R1: The configuration memory is laid out as follows: byte 0 is the offset, byte 1 is the first length N, then come N (match, mask) byte pairs, then the next length byte, and so on. A write with cfg_we high stores cfg_wdata at cfg_addr on the rising clock edge. Reset clears every byte to 0.
- R2: Payload position 0 is the first byte accepted with rx_valid after pkt_start. The bytes at positions offset to offset+N-1 form the address window, where buffer byte i is compared with entry byte i.
- R3: Byte i of an entry hits when ((rx[i] XOR match[i]) AND mask[i]) is zero. An entry hits only when all N of its bytes hit.
- R4: Entries are tried in memory order, and match rises together with done at the first hitting entry. When entry j (counting from 0) hits, done rises (j+1)*(N+1) clock edges after the edge that accepted the last window byte.
- R5: The walk ends without a match at the first length byte that differs from N (including 0x00), or whose entry would extend past the last memory byte. For k entries tried, done then rises k*(N+1)+1 edges after the last window byte, with match low.
- R6: When byte 1 is 0x00, address checking is disabled. done and match are both high after the pkt_start edge, and irq stays low.
- R7: If pkt_end arrives before the window is complete, done rises on that edge with match low.
- R8: irq is a one-cycle pulse, issued on the edge where match rises, only if irq_en was high. No pulse occurs otherwise.
- R9: pkt_start restarts the block: on that edge done, match and irq drop (except as in R6 and R10), and a byte presented in the same cycle as pkt_start is not counted.
- R10: done and match hold their values until the next pkt_start. Bytes and pkt_end that arrive after the verdict have no effect.
- R11: After reset, done, match and irq are low.
- R10 (limit part) / R12: A first length N greater than MAX_ADDR makes done rise after the pkt_start edge with match low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| irq_en | input | 1 | Address-match interrupt enable |
| pkt_start | input | 1 | Packet start strobe (after sync word) |
| rx_valid | input | 1 | rx_data holds a payload byte |
| rx_data | input | 8 | Received payload byte |
| pkt_end | input | 1 | Packet end strobe |
| match | output | 1 | Address accepted (valid while done) |
| done | output | 1 | Address decision made |
| irq | output | 1 | One-cycle match interrupt |

## Verification
A wrong pointer, byte index or running-hit flag inside the list walk does not raise a flag. It shows up at the ports as done rising a few edges early or late, or as match taking the wrong value for some entry position. For this reason, every packet is timed to the exact edge against the (j+1)*(N+1) and k*(N+1)+1 formulas, and its verdict and interrupt count are compared with a software walk of the same memory image. A broken position counter or capture buffer appears within one packet as a wrong verdict. A broken hold in DONE appears a few cycles after the trailing bytes, when done or match moves.

// File: rtl/addr_filter_pkg.sv
`timescale 1ns/1ps
package addr_filter_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_LEN,
        ST_CMP,
        ST_DONE
    } filt_state_e;
endpackage

// File: rtl/addr_cfg_mem.sv
`timescale 1ns/1ps
// Host-written configuration bytes with two combinational read ports.
module addr_cfg_mem #(
    parameter int DEPTH = 21,
    parameter int AW    = 5,
    parameter int PW    = 6,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr_a,
    input  logic [PW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b,
    output logic [DW-1:0] offset_o,
    output logic [DW-1:0] len_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we && (int'(waddr) < DEPTH)) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Reads beyond the last byte return zero, which acts as a list end.
    assign rdata_a  = (int'(raddr_a) < DEPTH) ? mem_q[raddr_a[AW-1:0]] : '0;
    assign rdata_b  = (int'(raddr_b) < DEPTH) ? mem_q[raddr_b[AW-1:0]] : '0;
    assign offset_o = mem_q[0];
    assign len_o    = mem_q[1];
endmodule

// File: rtl/addr_window.sv
`timescale 1ns/1ps
// Payload position counter and capture buffer for the address window.
module addr_window #(
    parameter int MAXB = 4,
    parameter int DW   = 8,
    parameter int IW   = 3,
    parameter int POSW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          active,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic [DW-1:0] offset,
    input  logic [DW-1:0] len,
    input  logic [IW-1:0] rd_idx,
    output logic          last,
    output logic [DW-1:0] rd_byte
);
    logic [POSW-1:0] pos_q;
    logic [DW-1:0]   buf_q [MAXB];
    logic [POSW-1:0] win_lo, win_hi, slot;
    logic            in_win;

    assign win_lo = POSW'(offset);
    assign win_hi = POSW'(offset) + POSW'(len);
    assign in_win = (pos_q >= win_lo) && (pos_q < win_hi);
    assign slot   = pos_q - win_lo;
    assign last   = active && rx_valid && in_win && ((pos_q + POSW'(1)) == win_hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            for (int i = 0; i < MAXB; i++) buf_q[i] <= '0;
        end else if (clear) begin
            pos_q <= '0;
            for (int i = 0; i < MAXB; i++) buf_q[i] <= '0;
        end else if (active && rx_valid) begin
            if (pos_q != '1) pos_q <= pos_q + POSW'(1);
            if (in_win && (slot < POSW'(MAXB))) buf_q[slot[IW-1:0]] <= rx_data;
        end
    end

    assign rd_byte = (int'(rd_idx) < MAXB) ? buf_q[rd_idx] : '0;
endmodule

// File: rtl/addr_byte_cmp.sv
`timescale 1ns/1ps
// Masked comparison of one received byte against one stored byte.
module addr_byte_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] ref_byte,
    input  logic [DW-1:0] mask_byte,
    output logic          hit
);
    assign hit = ((rx_byte ^ ref_byte) & mask_byte) == '0;
endmodule

// File: rtl/addr_filter.sv
`timescale 1ns/1ps
module addr_filter
    import addr_filter_pkg::*;
#(
    parameter int CFG_DEPTH = 21,
    parameter int MAX_ADDR  = 4,
    parameter int DW        = 8,
    localparam int CFG_AW   = $clog2(CFG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic              irq_en,
    input  logic              pkt_start,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_data,
    input  logic              pkt_end,
    output logic              match,
    output logic              done,
    output logic              irq
);
    localparam int PTR_W = CFG_AW + 1;
    localparam int IDX_W = $clog2(MAX_ADDR + 1);
    localparam int POS_W = DW + 2;
    localparam int SUM_W = PTR_W + DW + 1;

    filt_state_e       state_q, state_d;
    logic [PTR_W-1:0]  ptr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              ok_q, match_q, irq_q;
    logic [DW-1:0]     off_q, n_q;
    logic [DW-1:0]     rd_a, rd_b, cfg_off, cfg_len, win_byte;
    logic              win_last, byte_hit;
    logic              len_bad, bypass, last_byte, entry_fits, entry_hit, hit_now;

    addr_cfg_mem #(.DEPTH(CFG_DEPTH), .AW(CFG_AW), .PW(PTR_W), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
        .raddr_a(ptr_q), .raddr_b(ptr_q + PTR_W'(1)),
        .rdata_a(rd_a), .rdata_b(rd_b), .offset_o(cfg_off), .len_o(cfg_len)
    );

    addr_window #(.MAXB(MAX_ADDR), .DW(DW), .IW(IDX_W), .POSW(POS_W)) u_win (
        .clk(clk), .rst_n(rst_n), .clear(pkt_start),
        .active(state_q == ST_COLLECT), .rx_valid(rx_valid), .rx_data(rx_data),
        .offset(off_q), .len(n_q), .rd_idx(idx_q),
        .last(win_last), .rd_byte(win_byte)
    );

    addr_byte_cmp #(.DW(DW)) u_cmp (
        .rx_byte(win_byte), .ref_byte(rd_a), .mask_byte(rd_b), .hit(byte_hit)
    );

    assign bypass     = (cfg_len == '0);
    assign len_bad    = bypass || (int'(cfg_len) > MAX_ADDR);
    assign last_byte  = (DW'(idx_q) == (n_q - DW'(1)));
    assign entry_fits = (rd_a == n_q) &&
                        ((SUM_W'(ptr_q) + SUM_W'({n_q, 1'b0})) <= SUM_W'(CFG_DEPTH - 1));
    assign entry_hit  = ok_q && byte_hit;
    assign hit_now    = (state_q == ST_CMP) && last_byte && entry_hit;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_IDLE;
            ST_COLLECT: begin
                if (win_last)     state_d = ST_LEN;
                else if (pkt_end) state_d = ST_DONE;
            end
            ST_LEN:     state_d = entry_fits ? ST_CMP : ST_DONE;
            ST_CMP:     if (last_byte) state_d = entry_hit ? ST_DONE : ST_LEN;
            ST_DONE:    state_d = ST_DONE;
            default:    state_d = ST_IDLE;
        endcase
        if (pkt_start) state_d = len_bad ? ST_DONE : ST_COLLECT;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk pointer, byte index, running hit and latched packet settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= PTR_W'(1);
            idx_q <= '0;
            ok_q  <= 1'b1;
            off_q <= '0;
            n_q   <= '0;
        end else if (pkt_start) begin
            ptr_q <= PTR_W'(1);
            idx_q <= '0;
            ok_q  <= 1'b1;
            off_q <= cfg_off;
            n_q   <= cfg_len;
        end else if (state_q == ST_LEN && entry_fits) begin
            ptr_q <= ptr_q + PTR_W'(1);
            idx_q <= '0;
            ok_q  <= 1'b1;
        end else if (state_q == ST_CMP) begin
            ptr_q <= ptr_q + PTR_W'(2);
            idx_q <= idx_q + IDX_W'(1);
            ok_q  <= entry_hit;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            irq_q   <= 1'b0;
        end else if (pkt_start) begin
            match_q <= bypass;
            irq_q   <= 1'b0;
        end else if (hit_now) begin
            match_q <= 1'b1;
            irq_q   <= irq_en;
        end else begin
            irq_q   <= 1'b0;
        end
    end

    assign match = match_q;
    assign done  = (state_q == ST_DONE);
    assign irq   = irq_q;
endmodule

// File: rtl/addr_filter_chk.sv
`timescale 1ns/1ps
module addr_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic pkt_start,
    input logic irq_en,
    input logic match,
    input logic done,
    input logic irq
);
    assert_irq_with_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match && done));

    assert_irq_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);

    assert_verdict_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pkt_start) |=> (done && $stable(match)));

    assert_match_only_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> done);

    assert_start_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> !irq);
endmodule

bind addr_filter addr_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .irq_en(irq_en),
    .match(match), .done(done), .irq(irq)
);

// File: tb/addr_filter_tb.sv
`timescale 1ns/1ps
module addr_filter_tb;
    localparam int DEPTH = 21;
    localparam int MAXA  = 4;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       irq_en = 1'b0, pkt_start = 1'b0, rx_valid = 1'b0, pkt_end = 1'b0;
    logic [7:0] rx_data = '0;
    logic       match, done, irq;

    int checks = 0, fails = 0, irq_cnt = 0;
    logic [7:0] cfg_img [DEPTH];
    logic [7:0] rx_buf [64];

    addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq_en(irq_en), .pkt_start(pkt_start),
        .rx_valid(rx_valid), .rx_data(rx_data), .pkt_end(pkt_end),
        .match(match), .done(done), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cfg_rd(input int p);
        return (p < DEPTH) ? int'(cfg_img[p]) : 0;
    endfunction

    // Software walk of the list per R3/R4/R5
    function automatic void model(output bit hit, output int lat);
        int off, n, ptr;
        bit ok;
        off = cfg_img[0]; n = cfg_img[1]; ptr = 1; lat = 0; hit = 0;
        for (int guard = 0; guard < DEPTH; guard++) begin
            lat++;
            if (cfg_rd(ptr) != n || ptr + 2 * n > DEPTH - 1) return;
            ok = 1;
            for (int i = 0; i < n; i++)
                if (((int'(rx_buf[off + i]) ^ cfg_rd(ptr + 1 + 2 * i)) & cfg_rd(ptr + 2 + 2 * i)) != 0)
                    ok = 0;
            lat += n;
            if (ok) begin hit = 1; return; end
            ptr += 2 * n + 1;
        end
    endfunction

    task automatic write_cfg();
        for (int p = 0; p < DEPTH; p++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_addr = 5'(p); cfg_wdata = cfg_img[p];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_pkt(input bit with_byte, input logic [7:0] b);
        @(negedge clk);
        pkt_start = 1'b1; rx_valid = with_byte; rx_data = b;
        irq_cnt = 0;
        @(negedge clk);
        pkt_start = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic end_pkt();
        pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
    endtask

    // Full packet: window, timed verdict, trailing bytes, hold and interrupt count
    task automatic run_pkt(input int nb, input bit en, input bit ehit, input int elat, input string tag);
        int off, n, lat;
        off = cfg_img[0]; n = cfg_img[1];
        irq_en = en;
        start_pkt(1'b0, 8'h00);
        check({"R9 done cleared ", tag}, done, 0);
        for (int i = 0; i < off + n; i++) send_byte(rx_buf[i], $urandom % 3);
        lat = 0;
        while (!done && lat < 400) begin @(negedge clk); lat++; end
        check({ehit ? "R4 latency " : "R5 latency ", tag}, lat, elat);
        check({"R3 verdict ", tag}, match, ehit);
        for (int i = off + n; i < nb; i++) send_byte(rx_buf[i], 0);
        end_pkt();
        repeat (3) @(negedge clk);
        check({"R10 done held ", tag}, done, 1);
        check({"R10 match held ", tag}, match, ehit);
        check({"R8 irq count ", tag}, irq_cnt, (ehit && en) ? 1 : 0);
    endtask

    task automatic load_example();
        logic [7:0] img [DEPTH] = '{8'd2, 8'd4, 8'hAB, 8'hFF, 8'hCD, 8'hFF, 8'hEF, 8'hFF,
                                    8'h01, 8'hFF, 8'd4, 8'hAA, 8'hFF, 8'h00, 8'h00,
                                    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        for (int p = 0; p < DEPTH; p++) cfg_img[p] = img[p];
    endtask

    task automatic set_rx(input logic [7:0] b0, b1, b2, b3, b4, b5);
        rx_buf[0] = b0; rx_buf[1] = b1; rx_buf[2] = b2;
        rx_buf[3] = b3; rx_buf[4] = b4; rx_buf[5] = b5;
        for (int i = 6; i < 64; i++) rx_buf[i] = 8'(i);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lat, off, n, k, kmax, p, pick;
        bit ehit;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) rx_buf[i] = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 done after reset", done, 0);
        check("R11 match after reset", match, 0);
        check("R11 irq after reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R4: exact entry hits at entry 0, latency 1*(4+1)
        load_example(); write_cfg();
        set_rx(8'h11, 8'h22, 8'hAB, 8'hCD, 8'hEF, 8'h01);
        run_pkt(8, 1'b1, 1'b1, 5, "exact entry0");
        // R4: broadcast entry 1, latency 2*5, interrupt disabled (R8)
        set_rx(8'h00, 8'h00, 8'hAA, 8'h12, 8'h34, 8'h56);
        run_pkt(7, 1'b0, 1'b1, 10, "broadcast entry1");
        // R5: no entry hits, two entries tried then zero length: 2*5+1
        set_rx(8'h00, 8'h00, 8'hAB, 8'hCD, 8'hEF, 8'h02);
        run_pkt(6, 1'b1, 1'b0, 11, "miss zero-terminated");
        // R3: masked-off low nibble differs
        cfg_img[9] = 8'hF0; write_cfg();
        set_rx(8'h00, 8'h00, 8'hAB, 8'hCD, 8'hEF, 8'h0E);
        run_pkt(6, 1'b1, 1'b1, 5, "masked nibble");
        // R5: second entry length differs from N -> list end after 1*5+1
        cfg_img[9] = 8'hFF; cfg_img[10] = 8'd3; write_cfg();
        set_rx(8'h00, 8'h00, 8'hAA, 8'h12, 8'h34, 8'h56);
        run_pkt(6, 1'b1, 1'b0, 6, "length mismatch");

        // R6: checking disabled
        load_example(); cfg_img[1] = 8'd0; write_cfg();
        irq_en = 1'b1;
        start_pkt(1'b0, 8'h00);
        check("R6 done on start", done, 1);
        check("R6 match on start", match, 1);
        repeat (4) @(negedge clk);
        check("R6 no irq", irq_cnt, 0);

        // R12: N beyond MAX_ADDR
        cfg_img[1] = 8'd5; write_cfg();
        start_pkt(1'b0, 8'h00);
        check("R12 done on start", done, 1);
        check("R12 match low", match, 0);

        // R7: short packet
        load_example(); write_cfg();
        start_pkt(1'b0, 8'h00);
        send_byte(8'h00, 0); send_byte(8'h00, 1); send_byte(8'hAB, 0);
        check("R7 not done mid-window", done, 0);
        end_pkt();
        check("R7 done on early end", done, 1);
        check("R7 match low", match, 0);

        // R9: restart mid-walk cancels the pending hit
        set_rx(8'h00, 8'h00, 8'hAB, 8'hCD, 8'hEF, 8'h01);
        irq_en = 1'b1;
        start_pkt(1'b0, 8'h00);
        for (int i = 0; i < 6; i++) send_byte(rx_buf[i], 0);
        @(negedge clk);
        start_pkt(1'b0, 8'h00);
        check("R9 done after restart", done, 0);
        repeat (8) @(negedge clk);
        check("R9 cancelled walk silent", done + irq_cnt, 0);

        // R9/R2: byte in the pkt_start cycle is not counted (offset 0)
        cfg_img[0] = 8'd0; write_cfg();
        start_pkt(1'b1, 8'hAB);
        send_byte(8'hAB, 0); send_byte(8'hCD, 0); send_byte(8'hEF, 0); send_byte(8'h01, 0);
        repeat (6) @(negedge clk);
        check("R2 start-cycle byte ignored", match, 1);

        // Random configurations and packets
        for (int t = 0; t < 150; t++) begin
            off = $urandom % 6;
            n = 1 + $urandom % MAXA;
            kmax = (DEPTH - 2) / (2 * n + 1);
            k = 1 + $urandom % kmax;
            for (int q = 0; q < DEPTH; q++) cfg_img[q] = 8'($urandom);
            cfg_img[0] = 8'(off);
            p = 1;
            for (int e = 0; e < k; e++) begin
                cfg_img[p] = 8'(n);
                for (int i = 0; i < n; i++)
                    cfg_img[p + 2 + 2 * i] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
                p += 2 * n + 1;
            end
            if (p < DEPTH) cfg_img[p] = ($urandom % 3 == 0) ? 8'(n) : (($urandom % 2) ? 8'd0 : 8'($urandom % 8));
            for (int i = 0; i < 64; i++) rx_buf[i] = 8'($urandom);
            if ($urandom % 2) begin
                pick = 1 + ($urandom % k) * (2 * n + 1);
                for (int i = 0; i < n; i++)
                    rx_buf[off + i] = (cfg_img[pick + 1 + 2 * i] & cfg_img[pick + 2 + 2 * i]) |
                                      (8'($urandom) & ~cfg_img[pick + 2 + 2 * i]);
            end
            write_cfg();
            model(ehit, lat);
            run_pkt(off + n + $urandom % 4, 1'($urandom), ehit, lat, "random R1 R2");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule